// File: doc/BRIEF.md
# Dual-Set Pattern Bank Selector

This block sits in a cartridge mapper beside the video controller's pattern-memory bus. For every pattern fetch it picks which of two groups of bank registers supplies the upper address bits. It then returns the chosen bank number one clock later. The CPU loads the banks through mapper register writes. Group A holds eight registers, each serving a 1 KB window of the pattern space. Group B holds four registers, and the same four repeat across both 4 KB halves.

The block also watches CPU writes to the video controller. From the control register it learns the sprite size. From the mask register it learns whether the display is in forced blank, which it treats the same as any other non-rendering period. With small sprites every fetch uses group A. With tall sprites, sprite fetches use group A and background fetches use group B. A CPU data-port read outside rendering follows whichever group the CPU wrote last.

Top module: `chr_bank_select`

## Requirements
- R1: After a synchronous reset, every bank register and `bank_out` are zero. The last-written group is A, sprites are 8x8, and the display is in forced blank (both stored mask bits zero).
- R2: A mapper write with `map_wr_idx` 0..7 loads group A entry `idx`. Index 8..11 loads group B entry `idx-8`. Index 12..15 changes no bank and does not change the last-written group.
- R3: With 8x8 sprites, every fetch returns group A entry `fetch_addr[12:10]`, whatever `fetch_spr`, `rendering`, forced blank or the last-written group are.
- R4: With 8x16 sprites, while rendering and not in forced blank, a fetch with `fetch_spr`=1 returns group A entry `fetch_addr[12:10]`.
- R5: With 8x16 sprites, while rendering and not in forced blank, a fetch with `fetch_spr`=0 returns group B entry `fetch_addr[11:10]`. Bit 12 makes no difference.
- R6: With 8x16 sprites, while not rendering (`rendering`=0 or forced blank), a fetch returns group B entry `fetch_addr[11:10]` if the last write to a bank register hit group B. Otherwise it returns group A entry `fetch_addr[12:10]`. `fetch_spr` makes no difference.
- R7: Forced blank holds exactly when mask bits 3 and 4 (`vid_wr_sel`=1) were last written as both zero. Clearing only one of the two bits keeps rendering behaviour.
- R8: A write with `vid_wr_sel`=0 sets the sprite size from data bit 5 (1 = 8x16). No other bit of that write has any effect.
- R9: `bank_out` is registered. It shows the selection made from the inputs and register state present before the previous rising edge. A write in that same cycle takes effect on the following fetch.
- R10: Every write to a group A or group B index updates the last-written group, even when the data equals the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr_en | input | 1 | Mapper bank register write strobe |
| map_wr_idx | input | 4 | Bank register index (0..7 A, 8..11 B) |
| map_wr_data | input | 8 | Bank number to store |
| vid_wr_en | input | 1 | CPU write to a video controller register |
| vid_wr_sel | input | 1 | 0 = control register, 1 = mask register |
| vid_wr_data | input | 8 | Data of the video register write |
| rendering | input | 1 | Video controller is actively fetching for display |
| fetch_spr | input | 1 | Current fetch is a sprite pattern fetch |
| fetch_addr | input | 13 | Pattern address of the current fetch |
| bank_out | output | 8 | Selected bank number, registered |

## Verification
The bench walks through all four pairings of sprite size and last-written group. In each pairing it uses rendering sprite fetches, rendering background fetches and idle reads. A design that ignored the write history would return the wrong group on idle reads with tall sprites, and one that consulted it with small sprites would leak group B onto the bus. The bench clears only one mask bit at a time: a design that read either bit alone as forced blank would switch background fetches to the last-written group. It also writes to the unused indices 12..15, writes with the size bit clear but every other bit set, and uses background addresses with bit 12 high. An off-by-one in the B index fold or a stray decode would show up there as a wrong bank.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
  typedef enum logic { GRP_A = 1'b0, GRP_B = 1'b1 } grp_e;

  // Video-side register select codes for snooped CPU writes
  localparam logic VSEL_CTRL = 1'b0;
  localparam logic VSEL_MASK = 1'b1;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_bank_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int NUM_A  = 8,
  parameter int NUM_B  = 4,
  localparam int IDX_W   = $clog2(NUM_A + NUM_B),
  localparam int A_SEL_W = $clog2(NUM_A),
  localparam int B_SEL_W = $clog2(NUM_B)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BANK_W-1:0] wr_data,
  output logic [BANK_W-1:0] bank_a [NUM_A],
  output logic [BANK_W-1:0] bank_b [NUM_B],
  output grp_e              last_grp
);
  logic             hit_a, hit_b;
  logic [IDX_W-1:0] b_off;

  assign hit_a = wr_en && (wr_idx < IDX_W'(NUM_A));
  assign hit_b = wr_en && !hit_a && (wr_idx < IDX_W'(NUM_A + NUM_B));
  assign b_off = wr_idx - IDX_W'(NUM_A);

  for (genvar i = 0; i < NUM_A; i++) begin : g_grp_a
    always_ff @(posedge clk) begin
      if (rst)
        bank_a[i] <= '0;
      else if (hit_a && (wr_idx[A_SEL_W-1:0] == A_SEL_W'(i)))
        bank_a[i] <= wr_data;
    end
  end

  for (genvar j = 0; j < NUM_B; j++) begin : g_grp_b
    always_ff @(posedge clk) begin
      if (rst)
        bank_b[j] <= '0;
      else if (hit_b && (b_off[B_SEL_W-1:0] == B_SEL_W'(j)))
        bank_b[j] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        last_grp <= GRP_A;
    else if (hit_a) last_grp <= GRP_A;
    else if (hit_b) last_grp <= GRP_B;
  end

  // R10: a write into a group marks that group as most recent
  p_last_a_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx < IDX_W'(NUM_A)) |=> (last_grp == GRP_A));
  p_last_b_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= IDX_W'(NUM_A) && wr_idx < IDX_W'(NUM_A + NUM_B))
      |=> (last_grp == GRP_B));
  // R2: writes past the last group leave the history alone
  p_ign_idx_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= IDX_W'(NUM_A + NUM_B)) |=> $stable(last_grp));
endmodule

// File: rtl/chr_ppu_snoop.sv
module chr_ppu_snoop
  import chr_bank_pkg::*;
#(
  parameter int TALL_BIT  = 5,
  parameter int BG_EN_BIT = 3,
  parameter int SP_EN_BIT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vid_wr_en,
  input  logic       vid_wr_sel,
  input  logic [7:0] vid_wr_data,
  output logic       tall_spr,
  output logic       forced_blank
);
  logic bg_en_q, sp_en_q;
  logic unused_vid_bits;

  assign unused_vid_bits = ^vid_wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      tall_spr <= 1'b0;
      bg_en_q  <= 1'b0;
      sp_en_q  <= 1'b0;
    end else if (vid_wr_en) begin
      if (vid_wr_sel == VSEL_CTRL) begin
        tall_spr <= vid_wr_data[TALL_BIT];
      end else begin
        bg_en_q <= vid_wr_data[BG_EN_BIT];
        sp_en_q <= vid_wr_data[SP_EN_BIT];
      end
    end
  end

  // Only both layers off counts as blank
  assign forced_blank = ~(bg_en_q | sp_en_q);

  // R8: control write takes its size from the size bit only
  p_size_snoop_r8: assert property (@(posedge clk) disable iff (rst)
    (vid_wr_en && vid_wr_sel == VSEL_CTRL)
      |=> (tall_spr == $past(vid_wr_data[TALL_BIT])));
  // R7: one layer still enabled means no forced blank
  p_one_layer_r7: assert property (@(posedge clk) disable iff (rst)
    (vid_wr_en && vid_wr_sel == VSEL_MASK &&
     (vid_wr_data[BG_EN_BIT] ^ vid_wr_data[SP_EN_BIT])) |=> !forced_blank);
endmodule

// File: rtl/chr_bank_mux.sv
module chr_bank_mux
  import chr_bank_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 13,
  parameter int NUM_A  = 8,
  parameter int NUM_B  = 4,
  localparam int A_SEL_W = $clog2(NUM_A),
  localparam int B_SEL_W = $clog2(NUM_B),
  localparam int WIN_LSB = ADDR_W - A_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tall_spr,
  input  logic              forced_blank,
  input  logic              rendering,
  input  logic              fetch_spr,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [BANK_W-1:0] bank_a [NUM_A],
  input  logic [BANK_W-1:0] bank_b [NUM_B],
  input  grp_e              last_grp,
  output logic [BANK_W-1:0] bank_q,
  output logic              grp_b_q
);
  logic [A_SEL_W-1:0] a_idx;
  logic [B_SEL_W-1:0] b_idx;
  logic               idle, use_b;
  logic [BANK_W-1:0]  bank_d;
  logic               unused_addr;

  assign a_idx       = fetch_addr[WIN_LSB +: A_SEL_W];
  assign b_idx       = fetch_addr[WIN_LSB +: B_SEL_W];
  assign unused_addr = ^fetch_addr;
  assign idle        = forced_blank | ~rendering;

  always_comb begin
    use_b = 1'b0;
    if (tall_spr) begin
      if (idle) use_b = (last_grp == GRP_B);
      else      use_b = ~fetch_spr;
    end
    bank_d = use_b ? bank_b[b_idx] : bank_a[a_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q  <= '0;
      grp_b_q <= 1'b0;
    end else begin
      bank_q  <= bank_d;
      grp_b_q <= use_b;
    end
  end

  // R3: small sprites never reach the second group
  p_small_a_r3: assert property (@(posedge clk) disable iff (rst)
    !tall_spr |=> !grp_b_q);
  // R4: tall sprites, rendering, sprite fetch -> group A
  p_tall_spr_r4: assert property (@(posedge clk) disable iff (rst)
    (tall_spr && rendering && !forced_blank && fetch_spr) |=> !grp_b_q);
  // R5: tall sprites, rendering, background fetch -> group B
  p_tall_bg_r5: assert property (@(posedge clk) disable iff (rst)
    (tall_spr && rendering && !forced_blank && !fetch_spr) |=> grp_b_q);
  // R6: tall sprites, idle -> follows write history
  p_idle_hist_r6: assert property (@(posedge clk) disable iff (rst)
    (tall_spr && (forced_blank || !rendering))
      |=> (grp_b_q == $past(last_grp == GRP_B)));
endmodule

// File: rtl/chr_bank_select.sv
module chr_bank_select
  import chr_bank_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 13,
  parameter int NUM_A  = 8,
  parameter int NUM_B  = 4,
  localparam int IDX_W = $clog2(NUM_A + NUM_B)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_wr_en,
  input  logic [IDX_W-1:0]  map_wr_idx,
  input  logic [BANK_W-1:0] map_wr_data,
  input  logic              vid_wr_en,
  input  logic              vid_wr_sel,
  input  logic [7:0]        vid_wr_data,
  input  logic              rendering,
  input  logic              fetch_spr,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [BANK_W-1:0] bank_out
);
  logic [BANK_W-1:0] bank_a [NUM_A];
  logic [BANK_W-1:0] bank_b [NUM_B];
  grp_e              last_grp;
  logic              tall_spr, forced_blank, grp_b_q;

  chr_bank_regs #(.BANK_W(BANK_W), .NUM_A(NUM_A), .NUM_B(NUM_B)) u_regs (
    .clk(clk), .rst(rst), .wr_en(map_wr_en), .wr_idx(map_wr_idx),
    .wr_data(map_wr_data), .bank_a(bank_a), .bank_b(bank_b),
    .last_grp(last_grp)
  );

  chr_ppu_snoop u_snoop (
    .clk(clk), .rst(rst), .vid_wr_en(vid_wr_en), .vid_wr_sel(vid_wr_sel),
    .vid_wr_data(vid_wr_data), .tall_spr(tall_spr),
    .forced_blank(forced_blank)
  );

  chr_bank_mux #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .NUM_A(NUM_A),
                 .NUM_B(NUM_B)) u_mux (
    .clk(clk), .rst(rst), .tall_spr(tall_spr), .forced_blank(forced_blank),
    .rendering(rendering), .fetch_spr(fetch_spr), .fetch_addr(fetch_addr),
    .bank_a(bank_a), .bank_b(bank_b), .last_grp(last_grp),
    .bank_q(bank_out), .grp_b_q(grp_b_q)
  );

  // R1: the cycle after reset presents bank zero
  p_reset_zero_r1: assert property (@(posedge clk)
    $past(rst) |-> (bank_out == '0));
endmodule

// File: tb/tb_chr_bank_select.sv
module tb_chr_bank_select;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       map_wr_en = 1'b0;
  logic [3:0] map_wr_idx = '0;
  logic [7:0] map_wr_data = '0;
  logic       vid_wr_en = 1'b0;
  logic       vid_wr_sel = 1'b0;
  logic [7:0] vid_wr_data = '0;
  logic       rendering = 1'b0;
  logic       fetch_spr = 1'b0;
  logic [12:0] fetch_addr = '0;
  logic [7:0] bank_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  int  m_a [8];
  int  m_b [4];
  bit  m_tall, m_bg, m_sp, m_lastb;

  always #(CLK_P/2) clk = ~clk;

  chr_bank_select dut (
    .clk(clk), .rst(rst), .map_wr_en(map_wr_en), .map_wr_idx(map_wr_idx),
    .map_wr_data(map_wr_data), .vid_wr_en(vid_wr_en),
    .vid_wr_sel(vid_wr_sel), .vid_wr_data(vid_wr_data),
    .rendering(rendering), .fetch_spr(fetch_spr), .fetch_addr(fetch_addr),
    .bank_out(bank_out)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s bank_out=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_a[i] = 0;
    for (int i = 0; i < 4; i++) m_b[i] = 0;
    m_tall = 0; m_bg = 0; m_sp = 0; m_lastb = 0;
  endtask

  // One cycle: drive at negedge, predict, update model, compare one edge later (R9)
  task automatic step(input bit mw, input int midx, input int mdat,
                      input bit vw, input bit vsel, input int vdat,
                      input bit rend, input bit spr, input int addr);
    int exp;
    string tag;
    bit idle, fb;
    map_wr_en = mw; map_wr_idx = 4'(midx); map_wr_data = 8'(mdat);
    vid_wr_en = vw; vid_wr_sel = vsel; vid_wr_data = 8'(vdat);
    rendering = rend; fetch_spr = spr; fetch_addr = 13'(addr);
    fb   = !(m_bg || m_sp);
    idle = fb || !rend;
    if (!m_tall) begin
      exp = m_a[(addr >> 10) & 7]; tag = "R3";
    end else if (!idle) begin
      if (spr) begin exp = m_a[(addr >> 10) & 7]; tag = "R4"; end
      else     begin exp = m_b[(addr >> 10) & 3]; tag = "R5"; end
    end else begin
      exp = m_lastb ? m_b[(addr >> 10) & 3] : m_a[(addr >> 10) & 7];
      tag = (rend && fb) ? "R7/R6" : "R6";
    end
    if (mw) begin
      if (midx < 8)       begin m_a[midx] = mdat & 255; m_lastb = 0; end
      else if (midx < 12) begin m_b[midx-8] = mdat & 255; m_lastb = 1; end
    end
    if (vw) begin
      if (!vsel) m_tall = vdat[5];
      else begin m_bg = vdat[3]; m_sp = vdat[4]; end
    end
    @(posedge clk);
    @(negedge clk);
    chk(int'(bank_out), exp, tag);
  endtask

  task automatic fetch(input bit rend, input bit spr, input int addr);
    step(0, 0, 0, 0, 0, 0, rend, spr, addr);
  endtask

  task automatic sweep();
    for (int k = 0; k < 8; k++) begin
      fetch(1, 1, (k << 10) | 5);
      fetch(1, 0, (k << 10) | 9);
      fetch(0, k[0], (k << 10));
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(int'(bank_out), 0, "R1");
    // R1: zeroed banks, 8x8, forced blank
    fetch(1, 0, 13'h1C00);

    // R2: load both groups, distinct values
    for (int i = 0; i < 8; i++) step(1, i, 8'h10 + i, 0, 0, 0, 0, 0, 0);
    for (int j = 0; j < 4; j++) step(1, 8 + j, 8'h40 + j, 0, 0, 0, 0, 0, 0);
    // R2: indices 12..15 must leave everything intact
    for (int i = 12; i < 16; i++) step(1, i, 8'hEE, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'h18, 0, 0, 0); // enable both layers

    // all four pairings of sprite size and last-written group
    for (int sz = 0; sz < 2; sz++) begin
      for (int lg = 0; lg < 2; lg++) begin
        step(0, 0, 0, 1, 0, sz ? 8'h20 : 8'h00, 0, 0, 0);
        // R10: rewrite same value to set history
        if (lg == 1) step(1, 9, 8'h41, 0, 0, 0, 0, 0, 0);
        else         step(1, 2, 8'h12, 0, 0, 0, 0, 0, 0);
        // R2: ignored index after it must not flip history
        step(1, 14, 8'h77, 0, 0, 0, 0, 0, 0);
        sweep();
      end
    end

    // R7: each single-layer mask keeps rendering behaviour, both off blanks
    step(0, 0, 0, 1, 0, 8'h20, 0, 0, 0);
    step(1, 3, 8'h13, 0, 0, 0, 0, 0, 0);   // last group A
    step(0, 0, 0, 1, 1, 8'h08, 0, 0, 0);
    fetch(1, 0, 13'h1400);                  // R7 bg still B
    step(0, 0, 0, 1, 1, 8'h10, 0, 0, 0);
    fetch(1, 0, 13'h1800);                  // R7 bg still B
    step(0, 0, 0, 1, 1, 8'hE7, 0, 0, 0);
    fetch(1, 0, 13'h1800);                  // R7 forced blank -> A history

    // R8: every bit except size set -> small sprites
    step(0, 0, 0, 1, 1, 8'h18, 0, 0, 0);
    step(0, 0, 0, 1, 0, 8'hDF, 0, 0, 0);
    fetch(1, 0, 13'h1C00);                  // R8 group A
    step(0, 0, 0, 1, 0, 8'h20, 0, 0, 0);
    fetch(1, 0, 13'h1C00);                  // R8 tall -> group B

    // R9: write and fetch of the same entry in one cycle sees the old value
    step(1, 8 + 3, 8'h99, 0, 0, 0, 1, 0, 13'h0C00);
    fetch(1, 0, 13'h0C00);

    // mixed traffic, compared every clock
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom);
      step((r % 10) < 3, ($urandom % 16), ($urandom % 256),
           ((r >> 4) % 8) == 0, r[8], ($urandom % 256),
           r[9] | r[10], r[11], ($urandom % 8192));
    end

    // reset mid-run clears state (R1)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk(int'(bank_out), 0, "R1");
    fetch(1, 1, 13'h0400);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule